// File: doc/BRIEF.md
# Ping-Pong Peripheral DMA Channel

This block is one peripheral DMA channel that moves data between a device and memory through two buffer slots, A and B, used alternately. Software loads a start address and a byte count into a slot and marks the slot started. Software can refill the idle slot while the channel is still working on the other one, so a stream keeps running without gaps. When a slot runs out, the channel flags it done and moves on to the other slot if that slot is started. A status bit shows which slot is active. An interrupt output combines the done and error flags with an enable bit.

Software reaches the block through a word-addressed register bus. One status register appears at three addresses. At the set address, a written 1 sets the bit. At the clear address, a written 1 clears the bit. At the read address, a read returns the bits. A device register holds the direction, the beat width, the burst length and a peripheral select. The peripheral asks for a burst by raising a request line. The channel then issues one memory beat per cycle through a request/acknowledge handshake until the burst is used up.

Top module: `dbuf_dma_chan`

## Requirements
- R1: After reset every register reads 0, `irq` is low and `mem_req` is low.
- R2: Register word addresses (`reg_addr`) are: 0 device, 1 status set, 2 status clear, 3 status read, 4 slot A address, 5 slot A count, 6 slot B address, 7 slot B count. All three status addresses read the status register. Status bits are: 0 run, 1 interrupt enable, 2 error, 3 done A, 4 start A, 5 done B, 6 start B, 7 active slot (0 = A, 1 = B). Writing 1 at address 1 sets bits 6:0. Writing 1 at address 2 clears bits 6:0. A software write takes priority over a hardware update in the same cycle. Zero bits in the written value change nothing, and bit 7 cannot be written.
- R3: The device register reads back as written. `mem_write` follows bit 0 (1 = data comes from the device and is written to memory). `mem_half` follows bit 3 (1 = 2-byte beats, 0 = 1-byte beats). `periph_sel` follows bits 7:4. Bit 2 selects the burst length.
- R4: When no burst is in progress, the active slot is ready (run set, start set, count not zero) and `dev_req` is high, a burst of 4 beats is granted on the next edge, or 8 beats when device bit 2 is 1. `mem_req` is high only while the active slot is ready and burst beats remain.
- R5: Each accepted beat (`mem_req` and `mem_ack` with no `mem_err`) adds 1 or 2 to the active slot's address register and subtracts the same amount from its count, stopping at 0. `mem_addr` shows the active slot's address, so that register gives the current position.
- R6: When run is set, the active slot is started and its count is 0, the next edge sets its done bit, clears its start bit and drops any remaining burst. If the other slot is started, the active-slot bit also toggles.
- R7: When run is set, the active slot is not started and the other slot is started, the next edge toggles the active-slot bit.
- R8: `irq` is high exactly when interrupt enable is set and at least one of error, done A or done B is set.
- R9: While run is clear, no beat is requested and no slot completes. Setting run again continues from the address, count and burst left at the pause.
- R10: A beat acknowledged with `mem_err` high sets the error bit and clears run, and it does not move the address or the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register word address (byte offset bits 4:2) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| dev_req | input | 1 | Peripheral burst request |
| periph_sel | output | 4 | Selected peripheral |
| mem_req | output | 1 | Memory beat request |
| mem_addr | output | 32 | Address of the requested beat |
| mem_write | output | 1 | Beat writes memory (device to memory) |
| mem_half | output | 1 | Beat is 2 bytes wide |
| mem_ack | input | 1 | Beat accepted by memory |
| mem_err | input | 1 | Error response with `mem_ack` |
| irq | output | 1 | Interrupt |

## Verification
`mem_req`, `mem_addr`, `irq`, the device-derived outputs and `reg_rdata` come combinationally from registered state and the current inputs. They are therefore due in the same cycle that state is reached. Register writes, beats, burst grants, errors, slot completions and slot switches each take effect on the first rising edge after the cycle in which their condition holds. A completion therefore appears one edge after the count reaches zero, and a burst starts one edge after `dev_req` is seen. The bench drives inputs just after each rising edge. It updates its reference model at the rising edge and compares every output at the falling edge, so each comparison sees the state that the most recent edge produced. Directed readbacks after each scenario confirm the hand-computed final positions, counts and status values.

// File: rtl/dbuf_dma_pkg.sv
package dbuf_dma_pkg;

  // status bit positions
  localparam int ST_RUN     = 0;
  localparam int ST_IE      = 1;
  localparam int ST_ERR     = 2;
  localparam int ST_DONE_A  = 3;
  localparam int ST_START_A = 4;
  localparam int ST_DONE_B  = 5;
  localparam int ST_START_B = 6;
  localparam int ST_BIU     = 7;
  localparam int ST_SW_W    = 7;  // bits software may touch

  // device register field positions
  localparam int DV_DIR    = 0;
  localparam int DV_BURST  = 2;
  localparam int DV_WIDTH  = 3;
  localparam int DV_SEL_LO = 4;

  typedef enum logic [2:0] {
    RG_DEV   = 3'd0,
    RG_SET   = 3'd1,
    RG_CLR   = 3'd2,
    RG_STAT  = 3'd3,
    RG_A_ADR = 3'd4,
    RG_A_CNT = 3'd5,
    RG_B_ADR = 3'd6,
    RG_B_CNT = 3'd7
  } reg_sel_e;

  function automatic int done_pos(input logic slot);
    return slot ? ST_DONE_B : ST_DONE_A;
  endfunction

  function automatic int start_pos(input logic slot);
    return slot ? ST_START_B : ST_START_A;
  endfunction

  function automatic logic [1:0] beat_bytes(input logic wide);
    return wide ? 2'd2 : 2'd1;
  endfunction

  function automatic logic [3:0] burst_beats(input logic long_b);
    return long_b ? 4'd8 : 4'd4;
  endfunction

  // remaining count after one beat, floored at zero
  function automatic logic [31:0] count_after(input logic [31:0] cnt, input logic [1:0] step);
    if (cnt < {30'd0, step}) return 32'd0;
    return cnt - {30'd0, step};
  endfunction

endpackage

// File: rtl/dbuf_dma_slot.sv
module dbuf_dma_slot
  import dbuf_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 13
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_adr,
  input  logic              wr_cnt,
  input  logic [ADDR_W-1:0] wdata_adr,
  input  logic [CNT_W-1:0]  wdata_cnt,
  input  logic              adv,
  input  logic [1:0]        step,
  output logic [ADDR_W-1:0] adr_q,
  output logic [CNT_W-1:0]  cnt_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      adr_q <= '0;
      cnt_q <= '0;
    end else begin
      if (wr_adr)   adr_q <= wdata_adr;
      else if (adv) adr_q <= adr_q + ADDR_W'(step);
      if (wr_cnt)   cnt_q <= wdata_cnt;
      else if (adv) cnt_q <= CNT_W'(count_after(32'(cnt_q), step));
    end
  end

endmodule

// File: rtl/dbuf_dma_status.sv
module dbuf_dma_status
  import dbuf_dma_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_set,
  input  logic               wr_clr,
  input  logic [ST_SW_W-1:0] wdata,
  input  logic [1:0]         cpl_evt,
  input  logic               swap,
  input  logic               err_evt,
  output logic [7:0]         status_q
);

  logic [7:0] nxt;

  always_comb begin
    nxt = status_q;
    if (err_evt) begin
      nxt[ST_ERR] = 1'b1;
      nxt[ST_RUN] = 1'b0;
    end
    for (int s = 0; s < 2; s++) begin
      if (cpl_evt[s]) begin
        nxt[done_pos(s[0])]  = 1'b1;
        nxt[start_pos(s[0])] = 1'b0;
      end
    end
    if (swap) nxt[ST_BIU] = ~status_q[ST_BIU];
    // software writes override hardware updates
    if (wr_set) nxt[ST_SW_W-1:0] = nxt[ST_SW_W-1:0] | wdata;
    if (wr_clr) nxt[ST_SW_W-1:0] = nxt[ST_SW_W-1:0] & ~wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= nxt;
  end

endmodule

// File: rtl/dbuf_dma_engine.sv
module dbuf_dma_engine
  import dbuf_dma_pkg::*;
#(
  parameter int BL_W = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            start_act,
  input  logic            cnt_zero,
  input  logic            dev_req,
  input  logic            long_burst,
  input  logic            mem_ack,
  input  logic            mem_err,
  output logic            mem_req,
  output logic            beat,
  output logic            err_evt,
  output logic            cpl,
  output logic [BL_W-1:0] burst_left
);

  logic ready;

  assign ready   = run & start_act & ~cnt_zero;
  assign mem_req = ready & (burst_left != '0);
  assign beat    = mem_req & mem_ack & ~mem_err;
  assign err_evt = mem_req & mem_ack & mem_err;
  assign cpl     = run & start_act & cnt_zero;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      burst_left <= '0;
    end else if (cpl) begin
      burst_left <= '0;
    end else if (beat) begin
      burst_left <= burst_left - 1'b1;
    end else if (burst_left == '0 && dev_req && ready) begin
      burst_left <= BL_W'(burst_beats(long_burst));
    end
  end

endmodule

// File: rtl/dbuf_dma_chan.sv
module dbuf_dma_chan
  import dbuf_dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 13,
  parameter int BL_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [4:2]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              dev_req,
  output logic [3:0]        periph_sel,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_write,
  output logic              mem_half,
  input  logic              mem_ack,
  input  logic              mem_err,
  output logic              irq
);

  localparam int NSLOT = 2;

  reg_sel_e          sel;
  logic [31:0]       dev_q;
  logic [7:0]        status_q;
  logic              act;
  logic              run;
  logic              start_act;
  logic              start_oth;
  logic              cnt_zero;
  logic              swap;
  logic              beat;
  logic              err_evt;
  logic              cpl;
  logic [1:0]        cpl_evt;
  logic [1:0]        step;
  logic [BL_W-1:0]   burst_left;
  logic [NSLOT-1:0]  start_vec;
  logic [ADDR_W-1:0] slot_adr [NSLOT];
  logic [CNT_W-1:0]  slot_cnt [NSLOT];

  assign sel = reg_sel_e'(reg_addr);

  always_ff @(posedge clk) begin
    if (!rst_n)                       dev_q <= '0;
    else if (reg_wr && sel == RG_DEV) dev_q <= reg_wdata;
  end

  assign periph_sel = dev_q[DV_SEL_LO +: 4];
  assign mem_write  = dev_q[DV_DIR];
  assign mem_half   = dev_q[DV_WIDTH];
  assign step       = beat_bytes(dev_q[DV_WIDTH]);

  assign act       = status_q[ST_BIU];
  assign run       = status_q[ST_RUN];
  assign start_vec = {status_q[ST_START_B], status_q[ST_START_A]};
  assign start_act = start_vec[act];
  assign start_oth = start_vec[~act];
  assign cnt_zero  = (slot_cnt[act] == '0);
  assign swap      = run & start_oth & (~start_act | cnt_zero);
  assign cpl_evt   = cpl ? (act ? 2'b10 : 2'b01) : 2'b00;
  assign mem_addr  = slot_adr[act];

  dbuf_dma_status u_status (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_set   (reg_wr && sel == RG_SET),
    .wr_clr   (reg_wr && sel == RG_CLR),
    .wdata    (reg_wdata[ST_SW_W-1:0]),
    .cpl_evt  (cpl_evt),
    .swap     (swap),
    .err_evt  (err_evt),
    .status_q (status_q)
  );

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    localparam reg_sel_e SEL_ADR = (g == 0) ? RG_A_ADR : RG_B_ADR;
    localparam reg_sel_e SEL_CNT = (g == 0) ? RG_A_CNT : RG_B_CNT;
    dbuf_dma_slot #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_adr    (reg_wr && sel == SEL_ADR),
      .wr_cnt    (reg_wr && sel == SEL_CNT),
      .wdata_adr (reg_wdata[ADDR_W-1:0]),
      .wdata_cnt (reg_wdata[CNT_W-1:0]),
      .adv       (beat && (act == 1'(g))),
      .step      (step),
      .adr_q     (slot_adr[g]),
      .cnt_q     (slot_cnt[g])
    );
  end

  dbuf_dma_engine #(.BL_W(BL_W)) u_engine (
    .clk        (clk),
    .rst_n      (rst_n),
    .run        (run),
    .start_act  (start_act),
    .cnt_zero   (cnt_zero),
    .dev_req    (dev_req),
    .long_burst (dev_q[DV_BURST]),
    .mem_ack    (mem_ack),
    .mem_err    (mem_err),
    .mem_req    (mem_req),
    .beat       (beat),
    .err_evt    (err_evt),
    .cpl        (cpl),
    .burst_left (burst_left)
  );

  always_comb begin
    unique case (sel)
      RG_DEV:                   reg_rdata = dev_q;
      RG_SET, RG_CLR, RG_STAT:  reg_rdata = {24'd0, status_q};
      RG_A_ADR:                 reg_rdata = 32'(slot_adr[0]);
      RG_A_CNT:                 reg_rdata = 32'(slot_cnt[0]);
      RG_B_ADR:                 reg_rdata = 32'(slot_adr[1]);
      RG_B_CNT:                 reg_rdata = 32'(slot_cnt[1]);
      default:                  reg_rdata = '0;
    endcase
  end

  assign irq = status_q[ST_IE] &
               (status_q[ST_ERR] | status_q[ST_DONE_A] | status_q[ST_DONE_B]);

endmodule

// File: rtl/dbuf_dma_chk.sv
module dbuf_dma_chk #(
  parameter int BL_W = 4
) (
  input logic            clk,
  input logic            rst_n,
  input logic            reg_wr,
  input logic [7:0]      status,
  input logic            mem_req,
  input logic            mem_ack,
  input logic            mem_err,
  input logic            irq,
  input logic [1:0]      cpl_evt,
  input logic            swap,
  input logic [BL_W-1:0] burst_left
);

  AST_REQ_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> status[0]); // R9

  AST_IRQ_ON_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (status[1] && status[2]) |-> irq); // R8

  AST_IRQ_NEEDS_IE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> status[1]); // R8

  AST_ERR_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack && mem_err && !reg_wr) |=> (status[2] && !status[0])); // R10

  AST_DONE_A_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_evt[0] && !reg_wr) |=> (status[3] && !status[4])); // R6

  AST_DONE_B_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_evt[1] && !reg_wr) |=> (status[5] && !status[6])); // R6

  AST_SLOT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !swap |=> $stable(status[7])); // R7

  AST_BURST_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    burst_left <= BL_W'(8)); // R4

endmodule

bind dbuf_dma_chan dbuf_dma_chk #(.BL_W(BL_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .reg_wr     (reg_wr),
  .status     (status_q),
  .mem_req    (mem_req),
  .mem_ack    (mem_ack),
  .mem_err    (mem_err),
  .irq        (irq),
  .cpl_evt    (cpl_evt),
  .swap       (swap),
  .burst_left (burst_left)
);

// File: tb/dbuf_dma_chan_bench.sv
`timescale 1ns/1ps
module dbuf_dma_chan_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr;
  logic [4:2]  reg_addr;
  logic [31:0] reg_wdata;
  logic [31:0] reg_rdata;
  logic        dev_req;
  logic [3:0]  periph_sel;
  logic        mem_req;
  logic [31:0] mem_addr;
  logic        mem_write;
  logic        mem_half;
  logic        mem_ack;
  logic        mem_err;
  logic        irq;

  int n_chk = 0;
  int n_err = 0;
  bit finished = 1'b0;
  bit ack_rand = 1'b0;

  // reference model state
  logic [7:0]  m_st;
  logic [31:0] m_adr [2];
  int          m_cnt [2];
  int          m_bl;
  logic [31:0] m_dev;

  always #2.5 clk = ~clk;

  dbuf_dma_chan u_dbuf_dma_chan (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dev_req(dev_req),
    .periph_sel(periph_sel), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_write(mem_write), .mem_half(mem_half), .mem_ack(mem_ack),
    .mem_err(mem_err), .irq(irq)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  function automatic bit m_ready();
    int a;
    a = int'(m_st[7]);
    return m_st[0] && m_st[4 + 2*a] && (m_cnt[a] != 0);
  endfunction

  function automatic bit m_req();
    return m_ready() && (m_bl != 0);
  endfunction

  function automatic logic [31:0] m_read(input logic [2:0] a);
    case (a)
      3'd0:       return m_dev;
      3'd4:       return m_adr[0];
      3'd5:       return 32'(m_cnt[0]);
      3'd6:       return m_adr[1];
      3'd7:       return 32'(m_cnt[1]);
      default:    return {24'd0, m_st};
    endcase
  endfunction

  // model update at each rising edge
  always @(posedge clk) begin : model
    int a, o, bytes;
    bit run, sa, so, cz, rdy, rq;
    logic [7:0] n;
    if (!rst_n) begin
      m_st = 8'h00; m_adr[0] = 0; m_adr[1] = 0;
      m_cnt[0] = 0; m_cnt[1] = 0; m_bl = 0; m_dev = 0;
    end else begin
      a = int'(m_st[7]); o = 1 - a;
      run = m_st[0]; sa = m_st[4 + 2*a]; so = m_st[4 + 2*o];
      cz = (m_cnt[a] == 0);
      rdy = m_ready(); rq = m_req();
      bytes = m_dev[3] ? 2 : 1;
      n = m_st;
      if (rq && mem_ack && mem_err) begin
        n[2] = 1'b1; n[0] = 1'b0;
      end
      if (run && sa && cz) begin
        n[3 + 2*a] = 1'b1; n[4 + 2*a] = 1'b0;
        m_bl = 0;
      end else if (rq && mem_ack && !mem_err) begin
        m_adr[a] = m_adr[a] + bytes;
        m_cnt[a] = (m_cnt[a] < bytes) ? 0 : m_cnt[a] - bytes;
        m_bl = m_bl - 1;
      end else if (m_bl == 0 && dev_req && rdy) begin
        m_bl = m_dev[2] ? 8 : 4;
      end
      if (run && so && (!sa || cz)) n[7] = ~n[7];
      if (reg_wr) begin
        case (reg_addr)
          3'd0: m_dev = reg_wdata;
          3'd1: n[6:0] = n[6:0] | reg_wdata[6:0];
          3'd2: n[6:0] = n[6:0] & ~reg_wdata[6:0];
          3'd4: m_adr[0] = reg_wdata;
          3'd5: m_cnt[0] = int'(reg_wdata[12:0]);
          3'd6: m_adr[1] = reg_wdata;
          3'd7: m_cnt[1] = int'(reg_wdata[12:0]);
          default: ;
        endcase
      end
      m_st = n;
    end
  end

  // compare every cycle at the falling edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R4 mem_req", 32'(mem_req), 32'(m_req()));
      if (m_req()) chk("R5 mem_addr", mem_addr, m_adr[m_st[7]]);
      chk("R8 irq", 32'(irq), 32'(m_st[1] && (m_st[2] || m_st[3] || m_st[5])));
      chk("R3 fields", {26'd0, periph_sel, mem_write, mem_half},
          {26'd0, m_dev[7:4], m_dev[0], m_dev[3]});
      chk("R2 rdata", reg_rdata, m_read(reg_addr));
    end
  end

  always @(posedge clk) begin
    #1;
    if (ack_rand) mem_ack = 1'($urandom_range(0, 1));
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic look(input string tag, input logic [2:0] a, input logic [31:0] exp);
    reg_addr = a;
    @(negedge clk);
    chk(tag, reg_rdata, exp);
    tick();
  endtask

  task automatic pulse_req();
    dev_req = 1'b1; tick(); dev_req = 1'b0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++; n_err++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] pos0;
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = 3'd0; reg_wdata = 0;
    dev_req = 1'b0; mem_ack = 1'b0; mem_err = 1'b0;
    repeat (4) tick();
    rst_n = 1'b1;

    // R1: reset state
    look("R1 status", 3'd3, 32'h0);
    look("R1 slot A address", 3'd4, 32'h0);
    look("R1 slot B count", 3'd7, 32'h0);
    chk("R1 irq", 32'(irq), 32'h0);
    chk("R1 mem_req", 32'(mem_req), 32'h0);

    // R3: device register
    wr(3'd0, 32'h0000_00A9);
    look("R3 device readback", 3'd0, 32'h0000_00A9);
    chk("R3 periph_sel", 32'(periph_sel), 32'hA);
    chk("R3 mem_write", 32'(mem_write), 32'h1);
    chk("R3 mem_half", 32'(mem_half), 32'h1);

    // R2: set/clear aliases
    wr(3'd1, 32'h02);
    look("R2 set ie", 3'd3, 32'h02);
    wr(3'd1, 32'h80);
    look("R2 active bit read-only", 3'd3, 32'h02);
    wr(3'd2, 32'h00);
    look("R2 zero clear no effect", 3'd2, 32'h02);
    wr(3'd2, 32'h02);
    look("R2 clear ie", 3'd1, 32'h00);

    // R5/R6: A then B, random memory stalls
    wr(3'd4, 32'h1000); wr(3'd5, 32'd6);
    wr(3'd6, 32'h2000); wr(3'd7, 32'd4);
    dev_req = 1'b1; ack_rand = 1'b1;
    wr(3'd1, 32'h53);
    repeat (80) tick();
    ack_rand = 1'b0; mem_ack = 1'b1;
    look("R6 both slots done, B active", 3'd3, 32'hAB);
    look("R5 slot A end address", 3'd4, 32'h1006);
    look("R5 slot A count", 3'd5, 32'h0);
    look("R5 slot B end address", 3'd6, 32'h2004);

    // R7 switch to started A, then R10 error
    wr(3'd2, 32'h7F);
    wr(3'd4, 32'h3000); wr(3'd5, 32'd8);
    mem_err = 1'b1;
    wr(3'd1, 32'h13);
    repeat (10) tick();
    mem_err = 1'b0;
    look("R10 R7 error stops, A active", 3'd3, 32'h16);
    look("R10 no advance", 3'd4, 32'h3000);
    chk("R10 irq on error", 32'(irq), 32'h1);

    // R9 pause and resume
    wr(3'd2, 32'h04);
    wr(3'd1, 32'h01);
    tick();
    wr(3'd2, 32'h01);
    look("R9 paused position", 3'd4, m_adr[0]);
    pos0 = reg_rdata;
    repeat (5) tick();
    look("R9 position held", 3'd4, pos0);
    chk("R9 no request while paused", 32'(mem_req), 32'h0);
    wr(3'd1, 32'h01);
    repeat (30) tick();
    look("R9 resumed to end", 3'd4, 32'h3008);
    look("R6 A done", 3'd3, 32'h0B);
    wr(3'd2, 32'h02);
    chk("R8 irq off without ie", 32'(irq), 32'h0);
    look("R8 status", 3'd3, 32'h09);

    // R4 bursts of 8 single-byte beats
    dev_req = 1'b0;
    wr(3'd0, 32'h04);
    wr(3'd2, 32'h7F);
    wr(3'd4, 32'h4000); wr(3'd5, 32'd20);
    wr(3'd1, 32'h11);
    pulse_req();
    repeat (20) tick();
    look("R4 one 8-beat burst", 3'd4, 32'h4008);
    look("R4 count after burst", 3'd5, 32'd12);
    pulse_req();
    repeat (20) tick();
    look("R4 second burst", 3'd4, 32'h4010);
    pulse_req();
    repeat (20) tick();
    look("R6 burst cut at completion", 3'd4, 32'h4014);
    look("R6 status", 3'd3, 32'h09);

    // R5 floor at zero with 2-byte beats
    wr(3'd2, 32'h08);
    wr(3'd0, 32'h08);
    wr(3'd4, 32'h5000); wr(3'd5, 32'd3);
    wr(3'd1, 32'h10);
    pulse_req();
    repeat (15) tick();
    look("R5 odd count address", 3'd4, 32'h5004);
    look("R5 count floored", 3'd5, 32'h0);
    look("R6 done again", 3'd3, 32'h09);

    finished = 1'b1;
    summary();
    $finish;
  end

endmodule